// File: doc/BRIEF.md
# MSI Message Generator

This block sits in a PCIe endpoint. It holds the message-signalled interrupt capability registers and turns internal interrupt request lines into memory-write messages. Software programs a target address, which is split into low and high words, and a data value through a small register port. It then sets the enable bit. Each internal request becomes one write of the data value to that address. The low bits of the data carry the vector number, and the number of bits carried is limited by the enabled message count.

Requests are latched into a pending set. While the function is enabled, the lowest pending vector is sent first, with at most one message per cycle. A repeated request for a vector that is already pending is merged into the pending message. Messages leave on a valid/ready stream. A message stays on the output, with its address and data held, until the downstream side accepts it with ready high. After an accepted message, or with no message shown, the next message can appear in the following cycle.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, msg_valid is 0. The enable bit, the multi-message enable field, the 64-bit bit and the address and data registers are all 0. Register word 0 reads back the capability ID in bits 7:0 and the next pointer in bits 15:8, and both are fixed by parameters.
- R2: The register port has four words, selected by cfg_sel:
  - Word 0 is control: bit 16 is enable, bits 19:17 are the read-only multi-message capable value, bits 22:20 are multi-message enable, and bit 23 is 64-bit enable.
  - Word 1 is the low address. Bits 1:0 always read 0.
  - Word 2 is the high address.
  - Word 3 is data, held in bits 15:0.
  - Unlisted bits read 0, and writes to read-only bits are ignored.
- R3: A multi-message enable value written above the capable value is stored as the capable value.
- R4: msg_addr is {high word, low word} when 64-bit enable is 1, and {32'h0, low word} when it is 0.
- R5: msg_data is the data register with its low k bits replaced by the low k bits of the vector number, where k is the multi-message enable field. Bits 31:16 of msg_data are 0.
- R6: Pending vectors are sent lowest number first, one per cycle, while msg_ready is high.
- R7: While enable is 0, no new message is shown. Requests stay pending and are sent once enable is set.
- R8: A request for a vector that is already pending yields a single message.
- R9: A request for a vector that arrives in the same cycle that vector is taken for sending produces one further message for it.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_addr and msg_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected word (combinational) |
| irq_req | input | NUM_VEC | Internal request lines, one cycle per request |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Two functions can fall in the same cycle: taking a vector for sending, and a new request for that same vector. The test holds ready low so that one message waits at the output while a second vector is pending. It then raises ready in exactly the cycle that the second vector is taken, and pulses that vector's request in the same cycle. The scoreboard must then see that vector twice, in order after the first message. A merged request must instead appear once.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned MAX_LOG2 = 5;

  typedef struct packed {
    logic       en;
    logic [2:0] mme;
    logic       a64;
  } msi_ctrl_t;

  function automatic logic [DATA_W-1:0] vec_mask(input logic [2:0] mme);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(MAX_LOG2); i++)
      if (i < int'(mme)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter logic [7:0] CAP_ID   = 8'h05,
  parameter logic [7:0] NEXT_PTR = 8'h00,
  parameter logic [2:0] MMC      = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output msi_ctrl_t         ctrl,
  output logic [31:0]       addr_lo,
  output logic [31:0]       addr_hi,
  output logic [DATA_W-1:0] data
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:24], wdata[19:17], wdata[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
      data    <= '0;
    end else if (wr_en) begin
      case (sel)
        2'd0: begin
          ctrl.en  <= wdata[16];
          ctrl.mme <= (wdata[22:20] > MMC) ? MMC : wdata[22:20];
          ctrl.a64 <= wdata[23];
        end
        2'd1: addr_lo <= {wdata[31:2], 2'b00};
        2'd2: addr_hi <= wdata;
        default: data <= wdata[DATA_W-1:0];
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0: rdata = {8'h00, ctrl.a64, ctrl.mme, MMC, ctrl.en, NEXT_PTR, CAP_ID};
      2'd1: rdata = addr_lo;
      2'd2: rdata = addr_hi;
      default: rdata = {{(32-DATA_W){1'b0}}, data};
    endcase
  end

  // R3
  mme_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0) |=> (ctrl.mme <= MMC));
endmodule

// File: rtl/msi_pending.sv
module msi_pending #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  input  logic               en,
  input  logic               take_ok,
  output logic               issue,
  output logic [VEC_W-1:0]   issue_idx,
  output logic [NUM_VEC-1:0] pend_q
);
  logic [NUM_VEC-1:0] grant_oh;
  logic               any_pend;

  always_comb begin
    issue_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (pend_q[i]) issue_idx = VEC_W'(i);
  end

  assign any_pend = |pend_q;
  assign issue    = en && any_pend && take_ok;

  genvar g;
  generate
    for (g = 0; g < NUM_VEC; g++) begin : g_bit
      assign grant_oh[g] = issue && (issue_idx == VEC_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) pend_q[g] <= 1'b0;
        else        pend_q[g] <= (pend_q[g] && !grant_oh[g]) || req[g];
      end
    end
  endgenerate

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R8
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($countones(pend_q) <= $countones($past(pend_q)) + $countones($past(req))));
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VEC_W-1:0]  vec,
  input  msi_ctrl_t         ctrl,
  input  logic [31:0]       addr_lo,
  input  logic [31:0]       addr_hi,
  input  logic [DATA_W-1:0] data,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic              free
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] vec_ext;

  assign mask    = vec_mask(ctrl.mme);
  assign vec_ext = DATA_W'(vec);
  assign free    = !msg_valid || msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= {ctrl.a64 ? addr_hi : 32'h0, addr_lo};
      msg_data  <= {{(32-DATA_W){1'b0}}, (data & ~mask) | (vec_ext & mask)};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R10
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> ($stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 32,
  parameter logic [7:0]  CAP_ID   = 8'h05,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [2:0]  MMC      = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  msi_ctrl_t          ctrl;
  logic [31:0]        addr_lo, addr_hi;
  logic [DATA_W-1:0]  data;
  logic               issue, out_free;
  logic [VEC_W-1:0]   issue_idx;
  logic [NUM_VEC-1:0] pend_q;

  msi_cfg_regs #(.CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR), .MMC(MMC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl(ctrl),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data)
  );

  msi_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .en(ctrl.en),
    .take_ok(out_free), .issue(issue), .issue_idx(issue_idx), .pend_q(pend_q)
  );

  msi_msg_out #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(issue), .vec(issue_idx), .ctrl(ctrl),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .free(out_free)
  );

  // R7
  no_msg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !msg_valid) |=> !msg_valid);

  // R7
  pending_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && pend_q != '0 && !msg_valid) |=> msg_valid);
endmodule

// File: tb/tb_msi_msg_gen.sv
module tb_msi_msg_gen;
  localparam int NV = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_wr_en = 0;
  logic [1:0]    cfg_sel = 0;
  logic [31:0]   cfg_wdata = 0;
  logic [31:0]   cfg_rdata;
  logic [NV-1:0] irq_req = '0;
  logic          msg_valid;
  logic          msg_ready = 1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [95:0] exp_q[$];

  logic [31:0] m_lo, m_hi;
  logic [15:0] m_data;
  int          m_mme;
  bit          m_a64;

  always #10 clk = ~clk;

  msi_msg_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    cfg_sel = s;
    #1 v = cfg_rdata;
  endtask

  task automatic set_ctrl(input bit en, input int mme, input bit a64);
    wr(2'd0, {8'h0, a64, 3'(mme), 3'd0, en, 16'h0});
    m_mme = (mme > 5) ? 5 : mme;
    m_a64 = a64;
  endtask

  task automatic expect_vec(input int v);
    logic [15:0] mask;
    logic [15:0] d;
    mask = 16'((1 << m_mme) - 1);
    d = (m_data & ~mask) | (16'(v) & mask);
    exp_q.push_back({m_a64 ? m_hi : 32'h0, m_lo, 16'h0, d});
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic drain(input string req);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || msg_valid) && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(req, 96'(exp_q.size()), 96'd0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: actual unexpected message %h %h expected none", msg_addr, msg_data);
        end else begin
          check("R4/R5/R6 message", {msg_addr, msg_data}, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] a0;
    logic [31:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 check("R1 valid", 96'(msg_valid), 96'd0);
    rd(2'd0, r); check("R1 word0", 96'(r), 96'h000A_0005);
    rd(2'd1, r); check("R1 addr_lo", 96'(r), 96'd0);
    rd(2'd3, r); check("R1 data", 96'(r), 96'd0);

    // R2 register layout
    wr(2'd1, 32'hFEE0_0ABF); m_lo = 32'hFEE0_0ABC;
    wr(2'd2, 32'h1234_5678); m_hi = 32'h1234_5678;
    wr(2'd3, 32'hFFFF_4321); m_data = 16'h4321;
    rd(2'd1, r); check("R2 addr_lo low bits", 96'(r), 96'hFEE0_0ABC);
    rd(2'd2, r); check("R2 addr_hi", 96'(r), 96'h1234_5678);
    rd(2'd3, r); check("R2 data", 96'(r), 96'h4321);
    wr(2'd0, 32'hFF81_FFFF); m_mme = 0; m_a64 = 1;
    rd(2'd0, r); check("R2 ctrl ro bits", 96'(r), 96'h008B_0005);

    // R4 32-bit address, R5 no vector bits
    set_ctrl(1, 0, 0);
    expect_vec(5);
    pulse(NV'(1) << 5);
    drain("R4 single");

    // R5/R6 ordering with three vector bits, 64-bit address
    set_ctrl(1, 3, 1);
    expect_vec(2); expect_vec(6); expect_vec(9);
    pulse((NV'(1) << 2) | (NV'(1) << 9) | (NV'(1) << 6));
    drain("R6 order");

    // R3 clamp
    set_ctrl(1, 7, 1);
    rd(2'd0, r); check("R3 mme clamp", 96'(r[22:20]), 96'd5);
    expect_vec(31);
    pulse(NV'(1) << 31);
    drain("R5 five bits");

    // R7 disabled hold, R8 merge
    set_ctrl(0, 5, 1);
    pulse(NV'(1) << 4);
    pulse((NV'(1) << 4) | (NV'(1) << 1));
    repeat (4) @(negedge clk);
    check("R7 no msg while off", 96'(msg_valid), 96'd0);
    expect_vec(1); expect_vec(4);
    set_ctrl(1, 5, 1);
    drain("R7/R8 release");

    // R10 back-pressure
    @(negedge clk); msg_ready = 0;
    expect_vec(0); expect_vec(1); expect_vec(2); expect_vec(3);
    pulse(NV'(4'hF));
    repeat (2) @(negedge clk);
    a0 = msg_addr; d0 = msg_data;
    check("R10 valid held", 96'(msg_valid), 96'd1);
    repeat (3) @(negedge clk);
    check("R10 payload stable", {msg_addr, msg_data}, {a0, d0});
    check("R10 valid still", 96'(msg_valid), 96'd1);
    msg_ready = 1;
    drain("R10 drain");

    // R9 request in the cycle its vector is taken
    expect_vec(1); expect_vec(7); expect_vec(7);
    @(negedge clk); msg_ready = 0; irq_req = (NV'(1) << 1) | (NV'(1) << 7);
    @(negedge clk); irq_req = '0;
    @(negedge clk); msg_ready = 1; irq_req = NV'(1) << 7;
    @(negedge clk); irq_req = '0;
    drain("R9 same cycle");

    repeat (5) @(negedge clk);
    check("R8 nothing left", 96'(exp_q.size()), 96'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule